// File: doc/BRIEF.md
# Single-Bus Multicycle Processor Core

This block is a small 32-bit processor in which every register transfer crosses one shared internal bus. The program counter, a 32-entry register file, the instruction register, an ALU input latch (Y), an ALU output latch (Z), and the memory address and data registers all sit on that bus. A step sequencer picks the bus source for each clock cycle and raises the load enables. Every instruction is therefore a fixed series of one-cycle transfer steps. At each memory access the sequencer stalls in a wait step until the memory reports completion.

The core fetches and runs six instructions: register add, register bitwise AND, load word, store word, a read-modify-write memory AND, and a PC-relative branch. Any other encoding stops the core for good. External memory is word-addressed through the address register. A read or write starts with a one-cycle strobe. A read completes when the memory raises a one-cycle completion pulse with the data, after any number of cycles.

Top module: `sbc_core`

## Requirements
- R1: While reset is held, `mem_rd`, `mem_wr` and `halted` are low. The first memory read after reset fetches address 0.
- R2: Instruction fields are op = bits 31:26, rs = 25:21, rt = 20:16, rd = 15:11, shamt = 10:6, funct = 5:0 and immediate = 15:0. Each instruction that is not a branch is followed by a fetch at its own address plus 4.
- R3: When op = 0, shamt = 0 and funct = 32, register rd receives rs + rt, modulo 2^32.
- R4: When op = 0, shamt = 0 and funct = 36, register rd receives rs AND rt, bit by bit.
- R5: Op 35 (load) reads the word at rt + sign-extended immediate and writes it to register rs.
- R6: Op 43 (store) writes register rs to the word at rt + sign-extended immediate.
- R7: Op 1 reads the word at rt + sign-extended immediate. It then writes (rs AND that word) back to the same address.
- R8: Op 4 with rs = 0 and rt = 0 is a branch. The next fetch comes from (its address + 4) + (sign-extended immediate × 4). An immediate of 0 goes on in sequence, and a negative immediate branches backwards.
- R9: Any other encoding (another op, op 0 with another funct or a nonzero shamt, or op 4 with a nonzero rs or rt) raises `halted`. `halted` then stays high and no further memory strobe is issued.
- R10: Memory strobes last one cycle. After a read strobe the core waits for `mem_mfc` however late it comes. It holds `mem_addr` and issues no other strobe until `mem_mfc` arrives.
- R11: At most one source drives the internal bus in any cycle. The ALU result reaches the bus only through the Z latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 32 | Byte address of the current memory access |
| mem_wdata | output | 32 | Data to be written |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_rdata | input | 32 | Read data, valid with `mem_mfc` |
| mem_mfc | input | 1 | Read completion pulse |
| halted | output | 1 | High once an undecoded encoding has been fetched |

## Verification
The hardest case is the read-modify-write AND. There the register operand is latched into Y during the same wait step that is stalling for the memory. The write-back must then carry the new data to the address the read used, and a late completion pulse must neither corrupt Y nor move the address. The bench runs a program in which every read has a latency drawn at random from one to four cycles, so the wait steps of fetch, load and memory AND each stretch by different amounts. The program also chains forward, zero and backward branches, and the backward branch lands on an undecoded word. Skipped stores, the exact order of read addresses and the halt then all show up at the memory port.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int REG_AW = 5;
    localparam int IMM_W  = 16;
    localparam int OP_W   = 6;

    localparam logic [OP_W-1:0] OP_RTYPE = 6'd0;
    localparam logic [OP_W-1:0] OP_MAND  = 6'd1;
    localparam logic [OP_W-1:0] OP_BR    = 6'd4;
    localparam logic [OP_W-1:0] OP_LW    = 6'd35;
    localparam logic [OP_W-1:0] OP_SW    = 6'd43;
    localparam logic [5:0]      FN_ADD   = 6'd32;
    localparam logic [5:0]      FN_AND   = 6'd36;

    // bus source slots (one-hot select index)
    localparam int B_PC   = 0;
    localparam int B_C4   = 1;
    localparam int B_MDR  = 2;
    localparam int B_Z    = 3;
    localparam int B_REG  = 4;
    localparam int B_IMM  = 5;
    localparam int B_OFF  = 6;
    localparam int BUS_N  = 7;

    typedef enum logic [1:0] {SEL_RS, SEL_RT, SEL_RD} regsel_e;

    typedef enum logic [4:0] {
        ST_F1, ST_F2, ST_F3, ST_F4,
        ST_A1, ST_A2, ST_A3,
        ST_L1, ST_L2, ST_L3, ST_L4, ST_L5,
        ST_S1, ST_S2, ST_S3, ST_S4,
        ST_M1, ST_M2, ST_M3, ST_M4, ST_M5, ST_M6,
        ST_B1, ST_B2, ST_B3,
        ST_HALT
    } step_e;

    typedef struct packed {
        logic [BUS_N-1:0] bus_oh;
        logic             y_in;
        logic             z_in;
        logic             alu_and;
        logic             pc_in;
        logic             mar_in;
        logic             mdr_in;
        logic             ir_in;
        logic             reg_in;
        regsel_e          reg_sel;
        logic             rd_req;
        logic             wr_req;
    } ctl_t;
endpackage

// File: rtl/sbc_regfile.sv
module sbc_regfile #(
    parameter int W  = 32,
    parameter int N  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [N-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[addr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rdata = regs_q[addr];
endmodule

// File: rtl/sbc_alu.sv
module sbc_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         op_and,
    output logic [W-1:0] y
);
    always_comb begin
        if (op_and) y = a & b;
        else        y = a + b;
    end
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
    import sbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      ir,
    input  logic             mfc_ok,
    output ctl_t             ctl,
    output logic             halted
);
    step_e step_d, step_q;

    logic [OP_W-1:0] op;
    logic [4:0]      f_rs, f_rt, f_sh;
    logic [5:0]      f_fn;
    assign op   = ir[31:26];
    assign f_rs = ir[25:21];
    assign f_rt = ir[20:16];
    assign f_sh = ir[10:6];
    assign f_fn = ir[5:0];

    function automatic step_e dispatch(input logic [OP_W-1:0] o, input logic [4:0] s,
                                       input logic [4:0] t, input logic [4:0] sh,
                                       input logic [5:0] fn);
        step_e nxt;
        nxt = ST_HALT;
        case (o)
            OP_RTYPE: if (sh == 5'd0 && (fn == FN_ADD || fn == FN_AND)) nxt = ST_A1;
            OP_LW:    nxt = ST_L1;
            OP_SW:    nxt = ST_S1;
            OP_MAND:  nxt = ST_M1;
            OP_BR:    if (s == 5'd0 && t == 5'd0) nxt = ST_B1;
            default:  nxt = ST_HALT;
        endcase
        return nxt;
    endfunction

    always_comb begin
        ctl         = '0;
        ctl.reg_sel = SEL_RS;
        step_d      = step_q;
        case (step_q)
            // fetch
            ST_F1: begin ctl.bus_oh[B_PC] = 1'b1; ctl.mar_in = 1'b1; ctl.rd_req = 1'b1;
                         ctl.y_in = 1'b1; step_d = ST_F2; end
            ST_F2: begin ctl.bus_oh[B_C4] = 1'b1; ctl.z_in = 1'b1;
                         if (mfc_ok) step_d = ST_F3; end
            ST_F3: begin ctl.bus_oh[B_MDR] = 1'b1; ctl.ir_in = 1'b1; step_d = ST_F4; end
            ST_F4: begin ctl.bus_oh[B_Z] = 1'b1; ctl.pc_in = 1'b1;
                         step_d = dispatch(op, f_rs, f_rt, f_sh, f_fn); end
            // register add / and
            ST_A1: begin ctl.bus_oh[B_REG] = 1'b1; ctl.reg_sel = SEL_RS; ctl.y_in = 1'b1;
                         step_d = ST_A2; end
            ST_A2: begin ctl.bus_oh[B_REG] = 1'b1; ctl.reg_sel = SEL_RT; ctl.z_in = 1'b1;
                         ctl.alu_and = (f_fn == FN_AND); step_d = ST_A3; end
            ST_A3: begin ctl.bus_oh[B_Z] = 1'b1; ctl.reg_sel = SEL_RD; ctl.reg_in = 1'b1;
                         step_d = ST_F1; end
            // load
            ST_L1: begin ctl.bus_oh[B_REG] = 1'b1; ctl.reg_sel = SEL_RT; ctl.y_in = 1'b1;
                         step_d = ST_L2; end
            ST_L2: begin ctl.bus_oh[B_IMM] = 1'b1; ctl.z_in = 1'b1; step_d = ST_L3; end
            ST_L3: begin ctl.bus_oh[B_Z] = 1'b1; ctl.mar_in = 1'b1; ctl.rd_req = 1'b1;
                         step_d = ST_L4; end
            ST_L4: begin if (mfc_ok) step_d = ST_L5; end
            ST_L5: begin ctl.bus_oh[B_MDR] = 1'b1; ctl.reg_sel = SEL_RS; ctl.reg_in = 1'b1;
                         step_d = ST_F1; end
            // store
            ST_S1: begin ctl.bus_oh[B_REG] = 1'b1; ctl.reg_sel = SEL_RS; ctl.mdr_in = 1'b1;
                         step_d = ST_S2; end
            ST_S2: begin ctl.bus_oh[B_REG] = 1'b1; ctl.reg_sel = SEL_RT; ctl.y_in = 1'b1;
                         step_d = ST_S3; end
            ST_S3: begin ctl.bus_oh[B_IMM] = 1'b1; ctl.z_in = 1'b1; step_d = ST_S4; end
            ST_S4: begin ctl.bus_oh[B_Z] = 1'b1; ctl.mar_in = 1'b1; ctl.wr_req = 1'b1;
                         step_d = ST_F1; end
            // read-modify-write AND
            ST_M1: begin ctl.bus_oh[B_REG] = 1'b1; ctl.reg_sel = SEL_RT; ctl.y_in = 1'b1;
                         step_d = ST_M2; end
            ST_M2: begin ctl.bus_oh[B_IMM] = 1'b1; ctl.z_in = 1'b1; step_d = ST_M3; end
            ST_M3: begin ctl.bus_oh[B_Z] = 1'b1; ctl.mar_in = 1'b1; ctl.rd_req = 1'b1;
                         step_d = ST_M4; end
            ST_M4: begin ctl.bus_oh[B_REG] = 1'b1; ctl.reg_sel = SEL_RS; ctl.y_in = 1'b1;
                         if (mfc_ok) step_d = ST_M5; end
            ST_M5: begin ctl.bus_oh[B_MDR] = 1'b1; ctl.alu_and = 1'b1; ctl.z_in = 1'b1;
                         step_d = ST_M6; end
            ST_M6: begin ctl.bus_oh[B_Z] = 1'b1; ctl.mdr_in = 1'b1; ctl.wr_req = 1'b1;
                         step_d = ST_F1; end
            // branch
            ST_B1: begin ctl.bus_oh[B_OFF] = 1'b1; ctl.y_in = 1'b1; step_d = ST_B2; end
            ST_B2: begin ctl.bus_oh[B_PC] = 1'b1; ctl.z_in = 1'b1; step_d = ST_B3; end
            ST_B3: begin ctl.bus_oh[B_Z] = 1'b1; ctl.pc_in = 1'b1; step_d = ST_F1; end
            ST_HALT: step_d = ST_HALT;
            default: step_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_F1;
        else        step_q <= step_d;
    end

    assign halted = (step_q == ST_HALT);
endmodule

// File: rtl/sbc_core.sv
module sbc_core
    import sbc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         mem_rd,
    output logic         mem_wr,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_mfc,
    output logic         halted
);
    localparam int SEXT_W = W - IMM_W;

    typedef struct packed {
        logic [W-1:0] pc;
        logic [W-1:0] mar;
        logic [W-1:0] mdr;
        logic [W-1:0] ir;
        logic [W-1:0] y;
        logic [W-1:0] z;
        logic         rd;
        logic         wr;
        logic         pend;
    } dp_t;

    dp_t  dp_d, dp_q;
    ctl_t ctl;

    logic                      mfc_ok;
    logic [W-1:0]              bus;
    logic [W-1:0]              alu_y;
    logic [W-1:0]              reg_rdata;
    logic [REG_AW-1:0]         reg_addr;
    logic [W-1:0]              imm_sext;
    logic [W-1:0]              off_sext;
    logic [BUS_N-1:0][W-1:0]   src;

    assign mfc_ok   = mem_mfc && dp_q.pend;
    assign imm_sext = {{SEXT_W{dp_q.ir[IMM_W-1]}}, dp_q.ir[IMM_W-1:0]};
    assign off_sext = imm_sext << 2;

    always_comb begin
        case (ctl.reg_sel)
            SEL_RT:  reg_addr = dp_q.ir[20:16];
            SEL_RD:  reg_addr = dp_q.ir[15:11];
            default: reg_addr = dp_q.ir[25:21];
        endcase
    end

    assign src[B_PC]  = dp_q.pc;
    assign src[B_C4]  = W'(4);
    assign src[B_MDR] = dp_q.mdr;
    assign src[B_Z]   = dp_q.z;
    assign src[B_REG] = reg_rdata;
    assign src[B_IMM] = imm_sext;
    assign src[B_OFF] = off_sext;

    // AND-OR bus mux over the one-hot source select
    always_comb begin
        bus = '0;
        for (int i = 0; i < BUS_N; i++) begin
            if (ctl.bus_oh[i]) bus = bus | src[i];
        end
    end

    sbc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ir     (dp_q.ir[31:0]),
        .mfc_ok (mfc_ok),
        .ctl    (ctl),
        .halted (halted)
    );

    sbc_regfile #(.W(W), .N(NREG), .AW(REG_AW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl.reg_in),
        .addr  (reg_addr),
        .wdata (bus),
        .rdata (reg_rdata)
    );

    sbc_alu #(.W(W)) u_alu (
        .a      (dp_q.y),
        .b      (bus),
        .op_and (ctl.alu_and),
        .y      (alu_y)
    );

    always_comb begin
        dp_d = dp_q;
        if (ctl.pc_in)  dp_d.pc  = bus;
        if (ctl.mar_in) dp_d.mar = bus;
        if (ctl.ir_in)  dp_d.ir  = bus;
        if (ctl.y_in)   dp_d.y   = bus;
        if (ctl.z_in)   dp_d.z   = alu_y;
        if (ctl.mdr_in) dp_d.mdr = bus;
        else if (mfc_ok) dp_d.mdr = mem_rdata;
        dp_d.rd = ctl.rd_req;
        dp_d.wr = ctl.wr_req;
        if (ctl.rd_req)  dp_d.pend = 1'b1;
        else if (mfc_ok) dp_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign mem_addr  = dp_q.mar;
    assign mem_wdata = dp_q.mdr;
    assign mem_rd    = dp_q.rd;
    assign mem_wr    = dp_q.wr;
endmodule

// File: rtl/sbc_core_chk.sv
module sbc_core_chk
    import sbc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             mem_mfc,
    input logic [31:0]      mem_addr,
    input logic             halted,
    input logic [BUS_N-1:0] bus_oh
);
    logic pend_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (mem_rd)  pend_q <= 1'b1;
        else if (mem_mfc) pend_q <= 1'b0;
    end

    // R11
    one_bus_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_oh));

    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R10
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    // R10
    no_req_while_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (!mem_rd && !mem_wr));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !mem_mfc) |=> $stable(mem_addr));

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
endmodule

bind sbc_core sbc_core_chk u_sbc_core_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_mfc  (mem_mfc),
    .mem_addr (mem_addr[31:0]),
    .halted   (halted),
    .bus_oh   (ctl.bus_oh)
);

// File: tb/test_sbc_core.sv
module test_sbc_core;
    localparam time CLK_PERIOD = 10ns;
    localparam int  MEM_WORDS  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, mem_mfc, halted;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbc_core i_sbc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_rdata (mem_rdata),
        .mem_mfc   (mem_mfc),
        .halted    (halted)
    );

    // encodings per R2..R8
    function automatic logic [31:0] enc_r(input int s, input int t, input int d, input int fn);
        return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(input int op, input int s, input int t, input logic [15:0] im);
        return {6'(op), 5'(s), 5'(t), im};
    endfunction

    function automatic logic [31:0] init_word(input int i);
        case (i)
            0:  return enc_i(35, 1, 0, 16'h0200);   // lw  r1
            1:  return enc_i(35, 2, 0, 16'h0204);   // lw  r2
            2:  return enc_r(1, 2, 3, 32);          // add r3
            3:  return enc_r(1, 2, 4, 36);          // and r4
            4:  return enc_i(43, 3, 0, 16'h0210);   // sw  r3
            5:  return enc_i(43, 4, 0, 16'h0214);   // sw  r4
            6:  return enc_i(35, 5, 0, 16'h020C);   // lw  r5 = 5
            7:  return enc_i(1, 2, 5, 16'h0203);    // mem AND at 0x208
            8:  return enc_i(4, 0, 0, 16'h0001);    // br +1
            9:  return enc_i(43, 1, 0, 16'h0218);   // skipped
            10: return enc_i(4, 0, 0, 16'h0000);    // br 0
            11: return enc_i(4, 0, 0, 16'h0002);    // br +2
            12: return enc_i(43, 1, 0, 16'h0218);   // skipped
            13: return enc_i(43, 2, 0, 16'h0218);   // skipped
            14: return enc_i(43, 1, 0, 16'h021C);
            15: return enc_i(4, 0, 0, 16'h0001);    // br +1
            16: return 32'hFC00_0000;               // undecoded
            17: return enc_i(43, 2, 0, 16'h0220);
            18: return enc_i(4, 0, 0, 16'hFFFD);    // br -3
            128: return 32'h1234_5678;
            129: return 32'h0F0F_00FF;
            130: return 32'hFFFF_0000;
            131: return 32'h0000_0005;
            default: return 32'h0;
        endcase
    endfunction

    // behavioural memory with random completion latency
    logic [31:0] mem [MEM_WORDS];
    logic [31:0] lat_addr;
    int          lat_cnt;
    logic        pend_tb;
    int          strobe_in_pend;

    always @(posedge clk) begin
        mem_mfc <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < MEM_WORDS; i++) mem[i] <= init_word(i);
            lat_cnt   <= 0;
            lat_addr  <= '0;
            mem_rdata <= '0;
        end else begin
            if (mem_wr) mem[mem_addr[11:2]] <= mem_wdata;
            if (mem_rd) begin
                lat_addr <= mem_addr;
                lat_cnt  <= int'($urandom_range(4, 1));
            end else if (lat_cnt != 0) begin
                lat_cnt <= lat_cnt - 1;
                if (lat_cnt == 1) begin
                    mem_mfc   <= 1'b1;
                    mem_rdata <= mem[lat_addr[11:2]];
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // scoreboard
    logic [31:0] exp_rd_q[$];
    string       rd_tag_q[$];
    logic [31:0] exp_wa_q[$];
    logic [31:0] exp_wd_q[$];
    string       wr_tag_q[$];

    task automatic push_read(input logic [31:0] a, input string tag);
        exp_rd_q.push_back(a);
        rd_tag_q.push_back(tag);
    endtask
    task automatic push_write(input logic [31:0] a, input logic [31:0] d, input string tag);
        exp_wa_q.push_back(a);
        exp_wd_q.push_back(d);
        wr_tag_q.push_back(tag);
    endtask

    // monitor, samples between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if ((mem_rd || mem_wr) && pend_tb) strobe_in_pend++;
            if (mem_mfc) pend_tb = 1'b0;
            if (mem_rd) begin
                pend_tb = 1'b1;
                if (exp_rd_q.size() == 0) begin
                    check(1'b0, "R9 unexpected read", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] ea;
                    string       tg;
                    ea = exp_rd_q.pop_front();
                    tg = rd_tag_q.pop_front();
                    check(mem_addr == ea, tg, mem_addr, ea);
                end
            end
            if (mem_wr) begin
                if (exp_wa_q.size() == 0) begin
                    check(1'b0, "R8 unexpected write", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] ea, ed;
                    string       tg;
                    ea = exp_wa_q.pop_front();
                    ed = exp_wd_q.pop_front();
                    tg = wr_tag_q.pop_front();
                    check(mem_addr == ea, {tg, " addr"}, mem_addr, ea);
                    check(mem_wdata == ed, {tg, " data"}, mem_wdata, ed);
                end
            end
        end
    end

    initial begin
        int cyc;
        int quiet_bad;
        pend_tb        = 1'b0;
        strobe_in_pend = 0;

        // expected read order: fetches and data reads
        push_read(32'h000, "R1 first fetch");
        push_read(32'h200, "R5 load addr");
        push_read(32'h004, "R2 seq fetch");
        push_read(32'h204, "R5 load addr");
        push_read(32'h008, "R2 seq fetch");
        push_read(32'h00C, "R2 seq fetch");
        push_read(32'h010, "R2 seq fetch");
        push_read(32'h014, "R2 seq fetch");
        push_read(32'h018, "R2 seq fetch");
        push_read(32'h20C, "R5 load addr");
        push_read(32'h01C, "R2 seq fetch");
        push_read(32'h208, "R7 rmw read addr");
        push_read(32'h020, "R2 seq fetch");
        push_read(32'h028, "R8 fwd branch");
        push_read(32'h02C, "R8 zero branch");
        push_read(32'h038, "R8 fwd branch 2");
        push_read(32'h03C, "R2 seq fetch");
        push_read(32'h044, "R8 fwd branch");
        push_read(32'h048, "R2 seq fetch");
        push_read(32'h040, "R8 backward branch");

        push_write(32'h210, 32'h2143_5777, "R3 R11 add");
        push_write(32'h214, 32'h0204_0078, "R4 and");
        push_write(32'h208, 32'h0F0F_0000, "R7 rmw write");
        push_write(32'h21C, 32'h1234_5678, "R6 store");
        push_write(32'h220, 32'h0F0F_00FF, "R6 store after branch");

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!mem_rd && !mem_wr, "R1 strobes in reset", {30'd0, mem_rd, mem_wr}, 32'd0);
        check(!halted, "R1 halted in reset", {31'd0, halted}, 32'd0);
        rst_n = 1'b1;

        cyc = 0;
        while (!halted && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        @(negedge clk);
        check(halted, "R9 halt reached (watchdog)", {31'd0, halted}, 32'd1);

        quiet_bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (mem_rd || mem_wr || !halted) quiet_bad++;
        end
        check(quiet_bad == 0, "R9 quiet and sticky after halt", quiet_bad, 0);
        check(exp_rd_q.size() == 0, "R2 all reads seen", exp_rd_q.size(), 0);
        check(exp_wa_q.size() == 0, "R6 all writes seen", exp_wa_q.size(), 0);
        check(strobe_in_pend == 0, "R10 no strobe while read pending", strobe_in_pend, 0);
        check(mem[32'h208 >> 2] == 32'h0F0F_0000, "R7 memory word", mem[32'h208 >> 2], 32'h0F0F_0000);
        check(mem[32'h218 >> 2] == 32'h0, "R8 skipped stores", mem[32'h218 >> 2], 32'h0);
        check(mem[32'h210 >> 2] == 32'h2143_5777, "R3 memory word", mem[32'h210 >> 2], 32'h2143_5777);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule